// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block applies a new integer-mode divider set to a PLL's control register group without glitching the clocks that depend on it. A client presents a reference divider, a feedback multiplier and two post dividers, then pulses a start strobe. The block first checks the set against the legal VCO, output and multiplier ranges. An illegal set is refused at once and nothing is written to the PLL.

A legal set is applied as a fixed series of masked writes on a simple single-cycle write bus:

1. Put the PLL in slow (bypass) mode.
2. Force integer mode.
3. Write the feedback multiplier.
4. Write the reference and post dividers.

The block then polls the lock bit over the same bus. Once lock is seen, it returns the PLL to normal mode.

A programmable poll budget bounds the wait for lock. If the budget runs out, the PLL stays in slow mode and the block reports an error. The done and error flags hold until the next accepted start.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, busy, done and error are 0 and neither bus strobe is active.
- R2: A set is legal only if all of the following hold, with the reference taken as 24 MHz:
  - refdiv, postdiv1 and postdiv2 are nonzero.
  - VCO = 24·fbdiv/refdiv MHz lies in [800, 3200].
  - VCO/(postdiv1·postdiv2) lies in [16, 3200] MHz.
  An illegal set raises error on the cycle after start and issues no bus write.
- R3: fbdiv outside [16, 3200] is refused in the same way as in R2, even when the VCO is in range.
- R4: Every write is a 32-bit word whose bits [31:16] enable the matching bits of [15:0]. A legal set produces exactly five writes, in this order:
  - word 3 = 0x0300_0000 (mode field [9:8] = 0, slow);
  - word 3 = 0x0008_0008 (bit 3 = 1, integer mode);
  - word 0;
  - word 1;
  - word 3 = 0x0300_0100 (mode = 1, normal).
- R5: Word 0 carries fbdiv in [11:0] with enable mask 0x0FFF. Word 1 carries postdiv2 in [14:12], postdiv1 in [10:8] and refdiv in [5:0], with enable mask 0x773F.
- R6: Between the divider writes and the final write, the block reads word 2 each cycle. The normal-mode write follows only a read that returned bit 31 = 1.
- R7: If lockLimit consecutive polls see no lock, the block stops with error = 1 and issues no further writes. The mode field stays at slow. lockLimit must be at least 1.
- R8: busy is 1 from the cycle after an accepted start until the sequence ends. A start while busy is ignored.
- R9: done and error are never both 1. Each holds its value until the next start that is accepted in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start strobe, sampled in idle |
| refDivIn | input | 6 | Reference divider |
| fbDivIn | input | 12 | Feedback multiplier |
| postDiv1In | input | 3 | First post divider |
| postDiv2In | input | 3 | Second post divider |
| lockLimit | input | 16 | Poll budget in cycles (at least 1) |
| busWrEn | output | 1 | Write strobe |
| busRdEn | output | 1 | Read strobe |
| busAddr | output | 2 | Control word index |
| busWrData | output | 32 | Masked write word |
| busRdData | input | 32 | Read data, valid in the same cycle as busRdEn |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence finished with lock |
| error | output | 1 | Last request refused or lock timed out |

## Verification
On every cycle, the assertions check the following:
- The read and write strobes are never active together.
- done and error are exclusive.
- The end of busy always leaves one of them set.
- The normal-mode write follows a read that reported lock.
- The captured divider set stays stable between loads.
- The poll counter stays below its budget.

Only the bench's scenarios can show the rest:
- Exact write order, masks and field placement.
- Refusal at each range boundary.
- Timeout behaviour, including the slow mode left behind.
- Dropping a start that arrives while busy.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SLOW, ST_INT, ST_FB, ST_POST, ST_POLL, ST_NORM
  } seqState_t;

  typedef enum logic [2:0] {
    WK_SLOW, WK_INT, WK_FB, WK_POST, WK_NORM
  } wrKind_t;

  typedef struct packed {
    logic    ldCfg;
    logic    cntClr;
    logic    cntInc;
    wrKind_t wrKind;
  } seqCtrl_t;

  localparam int MODE_LO  = 8;
  localparam int DSM_BIT  = 3;
  localparam int LOCK_BIT = 31;
  localparam logic [1:0] WORD_FB   = 2'd0;
  localparam logic [1:0] WORD_DIV  = 2'd1;
  localparam logic [1:0] WORD_STAT = 2'd2;
  localparam logic [1:0] WORD_MODE = 2'd3;
endpackage

// File: rtl/pll_seq_datapath.sv
module pll_seq_datapath
  import pll_seq_pkg::*;
#(
  parameter int REF_W   = 6,
  parameter int FB_W    = 12,
  parameter int PD_W    = 3,
  parameter int CNT_W   = 16,
  parameter int REF_MHZ = 24,
  parameter int VCO_MIN = 800,
  parameter int VCO_MAX = 3200,
  parameter int OUT_MIN = 16,
  parameter int OUT_MAX = 3200,
  parameter int FB_MIN  = 16,
  parameter int FB_MAX  = 3200
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtrl_t         ctrl,
  input  logic [REF_W-1:0] refDivIn,
  input  logic [FB_W-1:0]  fbDivIn,
  input  logic [PD_W-1:0]  postDiv1In,
  input  logic [PD_W-1:0]  postDiv2In,
  input  logic [CNT_W-1:0] lockLimit,
  output logic             cfgOk,
  output logic             timeoutHit,
  output logic [1:0]       busAddr,
  output logic [31:0]      busWrData
);
  localparam int PW = 40;

  logic [REF_W-1:0] refQ;
  logic [FB_W-1:0]  fbQ;
  logic [PD_W-1:0]  pd1Q, pd2Q;
  logic [CNT_W-1:0] cntQ;

  logic [PW-1:0] fbScaled, refP, outDen;

  always_comb begin
    fbScaled = PW'(fbDivIn) * PW'(REF_MHZ);
    refP     = PW'(refDivIn);
    outDen   = refP * PW'(postDiv1In) * PW'(postDiv2In);
    cfgOk = (refDivIn != '0) && (postDiv1In != '0) && (postDiv2In != '0)
         && (fbDivIn >= FB_W'(FB_MIN)) && (fbDivIn <= FB_W'(FB_MAX))
         && (fbScaled >= refP * PW'(VCO_MIN)) && (fbScaled <= refP * PW'(VCO_MAX))
         && (fbScaled >= outDen * PW'(OUT_MIN)) && (fbScaled <= outDen * PW'(OUT_MAX));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refQ <= '0;
      fbQ  <= '0;
      pd1Q <= '0;
      pd2Q <= '0;
    end else if (ctrl.ldCfg) begin
      refQ <= refDivIn;
      fbQ  <= fbDivIn;
      pd1Q <= postDiv1In;
      pd2Q <= postDiv2In;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (ctrl.cntClr) cntQ <= '0;
    else if (ctrl.cntInc) cntQ <= cntQ + 1'b1;
  end

  assign timeoutHit = ({1'b0, cntQ} + 1'b1) >= {1'b0, lockLimit};

  always_comb begin
    busAddr   = WORD_MODE;
    busWrData = '0;
    unique case (ctrl.wrKind)
      WK_SLOW: busWrData = {16'h0300, 16'h0000};
      WK_INT:  busWrData = {16'h0008, 16'h0008};
      WK_FB: begin
        busAddr   = WORD_FB;
        busWrData = {16'h0FFF, 4'h0, 12'(fbQ)};
      end
      WK_POST: begin
        busAddr   = WORD_DIV;
        busWrData = {16'h773F, 1'b0, 3'(pd2Q), 1'b0, 3'(pd1Q), 2'b00, 6'(refQ)};
      end
      WK_NORM: busWrData = {16'h0300, 16'h0100};
      default: busWrData = '0;
    endcase
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.ldCfg |=> ($stable(fbQ) && $stable(refQ) && $stable(pd1Q) && $stable(pd2Q)));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntInc && lockLimit != '0) |-> cntQ < lockLimit);
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     cfgOk,
  input  logic     timeoutHit,
  input  logic     lockIn,
  output seqCtrl_t ctrl,
  output logic     busWrEn,
  output logic     busRdEn,
  output logic     busy,
  output logic     done,
  output logic     error
);
  seqState_t stateQ, stateD;
  logic doneQ, doneD, errQ, errD;

  always_comb begin
    stateD  = stateQ;
    doneD   = doneQ;
    errD    = errQ;
    ctrl    = '{ldCfg: 1'b0, cntClr: 1'b0, cntInc: 1'b0, wrKind: WK_SLOW};
    busWrEn = 1'b0;
    busRdEn = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (startReq) begin
        ctrl.ldCfg  = 1'b1;
        ctrl.cntClr = 1'b1;
        doneD       = 1'b0;
        errD        = !cfgOk;
        if (cfgOk) stateD = ST_SLOW;
      end
      ST_SLOW: begin busWrEn = 1'b1; ctrl.wrKind = WK_SLOW; stateD = ST_INT;  end
      ST_INT:  begin busWrEn = 1'b1; ctrl.wrKind = WK_INT;  stateD = ST_FB;   end
      ST_FB:   begin busWrEn = 1'b1; ctrl.wrKind = WK_FB;   stateD = ST_POST; end
      ST_POST: begin busWrEn = 1'b1; ctrl.wrKind = WK_POST; stateD = ST_POLL; end
      ST_POLL: begin
        busRdEn     = 1'b1;
        ctrl.wrKind = WK_NORM;
        if (lockIn) stateD = ST_NORM;
        else if (timeoutHit) begin
          stateD = ST_IDLE;
          errD   = 1'b1;
        end else ctrl.cntInc = 1'b1;
      end
      ST_NORM: begin
        busWrEn     = 1'b1;
        ctrl.wrKind = WK_NORM;
        stateD      = ST_IDLE;
        doneD       = 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= doneD;
      errQ   <= errD;
    end
  end

  assign busy  = stateQ != ST_IDLE;
  assign done  = doneQ;
  assign error = errQ;

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(done && error));

  // R8
  end_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || error));

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busWrEn, busRdEn}));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int REF_W = 6,
  parameter int FB_W  = 12,
  parameter int PD_W  = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [REF_W-1:0] refDivIn,
  input  logic [FB_W-1:0]  fbDivIn,
  input  logic [PD_W-1:0]  postDiv1In,
  input  logic [PD_W-1:0]  postDiv2In,
  input  logic [CNT_W-1:0] lockLimit,
  output logic             busWrEn,
  output logic             busRdEn,
  output logic [1:0]       busAddr,
  output logic [31:0]      busWrData,
  input  logic [31:0]      busRdData,
  output logic             busy,
  output logic             done,
  output logic             error
);
  seqCtrl_t ctrl;
  logic cfgOk, timeoutHit, rdAddr;
  logic [1:0] dpAddr;

  assign rdAddr  = busRdEn;
  assign busAddr = rdAddr ? WORD_STAT : dpAddr;

  pll_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cfgOk(cfgOk),
    .timeoutHit(timeoutHit), .lockIn(busRdData[LOCK_BIT]), .ctrl(ctrl),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busy(busy), .done(done), .error(error)
  );

  pll_seq_datapath #(.REF_W(REF_W), .FB_W(FB_W), .PD_W(PD_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .refDivIn(refDivIn), .fbDivIn(fbDivIn),
    .postDiv1In(postDiv1In), .postDiv2In(postDiv2In), .lockLimit(lockLimit),
    .cfgOk(cfgOk), .timeoutHit(timeoutHit), .busAddr(dpAddr), .busWrData(busWrData)
  );

  // R6
  norm_after_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == WORD_MODE && busWrData[MODE_LO] && busWrData[16+MODE_LO])
      |-> $past(busRdEn && busRdData[LOCK_BIT]));
endmodule

// File: tb/test_pll_reprog_seq.sv
module test_pll_reprog_seq;
  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0;
  logic [5:0] refDivIn = '0;
  logic [11:0] fbDivIn = '0;
  logic [2:0] postDiv1In = '0, postDiv2In = '0;
  logic [15:0] lockLimit = 16'd20;
  logic busWrEn, busRdEn, busy, done, error;
  logic [1:0] busAddr;
  logic [31:0] busWrData, busRdData;

  always #10 clk = ~clk;

  pll_reprog_seq i_pll_reprog_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .refDivIn(refDivIn), .fbDivIn(fbDivIn),
    .postDiv1In(postDiv1In), .postDiv2In(postDiv2In), .lockLimit(lockLimit),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .busy(busy), .done(done), .error(error)
  );

  // PLL register model
  logic [15:0] regs [4];
  logic armed = 1'b0, clearLog = 1'b0, orderBad, slowBad, normBad;
  int lockCnt = 0, lockDelay = 3, wrCount, rdCount;
  logic [1:0] wrAddrLog [8];
  logic [31:0] wrDataLog [8];
  logic lockBit;
  assign lockBit = armed && (lockCnt >= lockDelay);
  assign busRdData = {lockBit, 15'b0, regs[busAddr]};

  initial begin
    regs[0] = '0; regs[1] = '0; regs[2] = '0; regs[3] = 16'h0100;
  end

  always @(posedge clk) begin
    if (clearLog) begin
      wrCount <= 0; rdCount <= 0; orderBad <= 1'b0; slowBad <= 1'b0; normBad <= 1'b0;
    end else begin
      if (busRdEn) rdCount <= rdCount + 1;
      if (busWrEn) begin
        if (wrCount < 8) begin
          wrAddrLog[wrCount] <= busAddr;
          wrDataLog[wrCount] <= busWrData;
        end
        wrCount <= wrCount + 1;
        regs[busAddr] <= (regs[busAddr] & ~busWrData[31:16]) | (busWrData[15:0] & busWrData[31:16]);
        if (busAddr <= 2'd1 && (regs[3][9:8] != 2'd0 || !regs[3][3])) slowBad <= 1'b1;
        if (busAddr == 2'd3 && busWrData[24] && busWrData[8] && !lockBit) normBad <= 1'b1;
      end
    end
    if (busWrEn && busAddr == 2'd0) armed <= 1'b0;
    if (busWrEn && busAddr == 2'd1) begin
      armed <= 1'b1; lockCnt <= 0;
    end else if (lockCnt < 100000) lockCnt <= lockCnt + 1;
  end

  int checks = 0, errors = 0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runCfg(input logic [5:0] r, input logic [11:0] f, input logic [2:0] a,
                        input logic [2:0] b);
    @(negedge clk); clearLog = 1'b1;
    @(negedge clk); clearLog = 1'b0;
    refDivIn = r; fbDivIn = f; postDiv1In = a; postDiv2In = b; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // {ref, fb, postdiv1, postdiv2, legal}
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {6'd3,  12'd200,  3'd1, 3'd1, 1'b1},
    {6'd1,  12'd50,   3'd2, 3'd1, 1'b1},
    {6'd3,  12'd100,  3'd1, 3'd1, 1'b1},
    {6'd3,  12'd99,   3'd1, 3'd1, 1'b0},
    {6'd3,  12'd400,  3'd1, 3'd1, 1'b1},
    {6'd3,  12'd401,  3'd1, 3'd1, 1'b0},
    {6'd30, 12'd3201, 3'd1, 3'd1, 1'b0},
    {6'd24, 12'd3200, 3'd1, 3'd1, 1'b1},
    {6'd2,  12'd100,  3'd0, 3'd1, 1'b0},
    {6'd0,  12'd100,  3'd1, 3'd1, 1'b0},
    {6'd1,  12'd34,   3'd7, 3'd7, 1'b1},
    {6'd1,  12'd15,   3'd1, 3'd1, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearLog = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error && !busWrEn && !busRdEn, "R1 reset outputs",
        {busy, done, error, busWrEn, busRdEn}, 0);
    rstN = 1'b1; clearLog = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [5:0] r; logic [11:0] f; logic [2:0] a, b; logic ok; logic [15:0] fbPrev;
      {r, f, a, b, ok} = VEC[i];
      fbPrev = regs[0];
      runCfg(r, f, a, b);
      if (ok) begin
        chk(done && !error, "R9 done flag", {done, error}, 2'b10);
        chk(wrCount == 5, "R4 write count", wrCount, 5);
        chk(wrAddrLog[0] == 3 && wrDataLog[0] == 32'h0300_0000 &&
            wrAddrLog[1] == 3 && wrDataLog[1] == 32'h0008_0008 &&
            wrAddrLog[2] == 0 && wrAddrLog[3] == 1 &&
            wrAddrLog[4] == 3 && wrDataLog[4] == 32'h0300_0100,
            "R4 order", wrDataLog[4], 32'h0300_0100);
        chk(wrDataLog[2] == {16'h0FFF, 4'h0, f}, "R5 word0", wrDataLog[2], {16'h0FFF, 4'h0, f});
        chk(wrDataLog[3] == {16'h773F, 1'b0, b, 1'b0, a, 2'b00, r}, "R5 word1",
            wrDataLog[3], {16'h773F, 1'b0, b, 1'b0, a, 2'b00, r});
        chk(!slowBad && regs[3][9:8] == 2'd1 && regs[3][3], "R4 slow during update, normal at end",
            {slowBad, regs[3]}, 16'h0108);
        chk(!normBad && rdCount == lockDelay + 1, "R6 poll then normal", rdCount, lockDelay + 1);
      end else begin
        chk(error && !done, (f > 3200 || f < 16) ? "R3 refused" : "R2 refused",
            {done, error}, 2'b01);
        chk(wrCount == 0 && regs[0] == fbPrev, "R2 no writes", wrCount, 0);
      end
    end

    // R9 flags hold while idle
    runCfg(6'd1, 12'd50, 3'd2, 3'd1);
    repeat (10) @(negedge clk);
    chk(done && !error, "R9 done held", {done, error}, 2'b10);

    // R8 start while busy ignored
    @(negedge clk); clearLog = 1'b1;
    @(negedge clk); clearLog = 1'b0;
    refDivIn = 6'd1; fbDivIn = 12'd40; postDiv1In = 3'd2; postDiv2In = 3'd1; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    chk(busy, "R8 busy raised", busy, 1);
    @(negedge clk);
    fbDivIn = 12'd60; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(regs[0] == 16'd40 && wrCount == 5, "R8 second start ignored", regs[0], 40);

    // R7 lock timeout
    lockDelay = 1000; lockLimit = 16'd20;
    runCfg(6'd3, 12'd200, 3'd1, 3'd1);
    chk(error && !done, "R7 timeout error", {done, error}, 2'b01);
    chk(wrCount == 4 && rdCount == 20, "R7 writes and polls", {wrCount, rdCount}, {32'd4, 32'd20});
    chk(regs[3][9:8] == 2'd0, "R7 left slow", regs[3][9:8], 0);
    lockDelay = 3;

    // R9 a refused request after a good one clears done
    runCfg(6'd1, 12'd50, 3'd2, 3'd1);
    runCfg(6'd3, 12'd99, 3'd1, 3'd1);
    chk(error && !done, "R9 refusal clears done", {done, error}, 2'b01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule